// File: doc/BRIEF.md
# QDR-II Four-Beat Burst SRAM Controller

This block sits between a user-side request interface and a quad-data-rate static RAM with separate read and write data paths and a fixed burst of four beats. It runs on an internal clock at twice the memory's K rate, so every internal clock edge is one half of a memory cycle. The block derives the K phase from a toggling register. It drives both active-low port selects, the two burst addresses, the write data beats and the active-low byte masks. It collects the four read beats that return and hands them back as one wide word.

The read and write sides are arbitrated independently, so a read and a write may start on the same K rise. Each side carries a one-cycle blocking flag. After a side has launched a request, its ready is withdrawn for the following K cycle, because the memory would silently drop a second request of the same type on the next K rise. A request is accepted on the internal edge that closes the K-high half (the K# rise). Its select is then low for exactly one half-cycle and is sampled by the memory on the following K rise.

Top module: `qdr4_ctrl`

## Requirements
- R1: After reset is released and before any request, both selects are high, every byte mask bit is high, the read response valid is low and `mem_kphase` toggles on every clock edge.
- R2: A request is accepted only on an edge where its ready is high, and ready is high only in the K-high half. On the next half-cycle the matching select is low and the matching address output carries the request address.
- R3: After a read (or write) is accepted, that side's ready stays low for the next three half-cycles. Two same-type acceptances are therefore at least four half-cycles apart.
- R4: A select that was sampled low at one K rise is high at the next K rise, so the memory never sees two consecutive same-type requests.
- R5: For a write sampled at K rise tick T, beat j (bits `[36j+35:36j]` of `wr_req_data`) is on `mem_d` at the edge T+2+j. These are the K and K# rises of the next two cycles, and beat j is stored at word 4·A+j.
- R6: With each write beat j, `mem_bmask_n[i]` equals the inverse of `wr_req_be[4j+i]`, and lane i covers bits `[9i+8:9i]` of that beat.
- R7: Whenever no write beat is being presented, all byte mask bits are high and `mem_d` is zero.
- R8: For a read sampled at K rise tick T, beats are captured at edges T+3 to T+6. `rd_rsp_valid` is high for exactly one clock, seven clocks after acceptance, and beat j sits in bits `[36j+35:36j]` of `rd_rsp_data`.
- R9: A read and a write offered together in the same K-high half are both accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the memory K rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request can be taken on this edge |
| rd_req_addr | input | ADDR_W | Burst address of the read |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write request can be taken on this edge |
| wr_req_addr | input | ADDR_W | Burst address of the write |
| wr_req_data | input | 4·DATA_W | Four write beats, beat 0 in the low bits |
| wr_req_be | input | 4·DATA_W/9 | Active-high byte enables, four lanes per beat |
| rd_rsp_valid | output | 1 | One-clock pulse marking a completed read |
| rd_rsp_data | output | 4·DATA_W | Four read beats, beat 0 in the low bits |
| mem_kphase | output | 1 | K clock to the memory, high in the half after a K rise |
| mem_rsel_n | output | 1 | Active-low read select |
| mem_rd_addr | output | ADDR_W | Read burst address |
| mem_wsel_n | output | 1 | Active-low write select |
| mem_wr_addr | output | ADDR_W | Write burst address |
| mem_bmask_n | output | DATA_W/9 | Active-low byte masks for the current write beat |
| mem_d | output | DATA_W | Write data beat |
| mem_q | input | DATA_W | Read data beat from the memory |

## Verification
The bench drives two reads in a row and two writes in a row. If the blocking flag were lost, the second select would land on the next K rise and the responder model would drop it. The scoreboard would then see a missing or stale word and a gap shorter than four half-cycles. A write under a sparse byte-enable pattern checks lane order and beat order: a swapped lane or a beat shifted by one half-cycle returns visibly corrupted data. A read and a write offered together must leave on the same edge, so a design that serialises the two sides shows mismatched acceptance ticks. Every response is also timed against its acceptance, so a capture window off by one tick fails both the latency check and the data check.

// File: rtl/qdr4_pkg.sv
`timescale 1ns/1ps
package qdr4_pkg;
   localparam int BURST  = 4;
   localparam int LANE_W = 9;

   typedef enum logic {
      PH_K_LOW  = 1'b0,
      PH_K_HIGH = 1'b1
   } kphase_e;
endpackage

// File: rtl/qdr4_port_issue.sv
`timescale 1ns/1ps
module qdr4_port_issue #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              accept,
   output logic              sel_n,
   output logic [ADDR_W-1:0] mem_addr
);
   logic blocked;

   assign req_ready = launch & ~blocked;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n    <= 1'b1;
         blocked  <= 1'b0;
         mem_addr <= '0;
      end else begin
         sel_n <= ~accept;
         if (launch) blocked <= accept;
         if (accept) mem_addr <= req_addr;
      end
   end

   // R4: a select low at one K rise must be high at the next one
   a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n |=> ##1 sel_n);

   // R3: ready withdrawn through the blocked K cycle
   a_r3_ready_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ##1 !req_ready);
endmodule

// File: rtl/qdr4_wr_beats.sv
`timescale 1ns/1ps
module qdr4_wr_beats #(
   parameter int DATA_W = 36,
   parameter int LANES  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            accept,
   input  logic [qdr4_pkg::BURST*DATA_W-1:0] wr_data,
   input  logic [qdr4_pkg::BURST*LANES-1:0]  wr_be,
   output logic [DATA_W-1:0]               mem_d,
   output logic [LANES-1:0]                mem_bmask_n
);
   localparam int NB   = qdr4_pkg::BURST;
   localparam int LW   = $clog2(NB + 1);

   logic [NB*DATA_W-1:0] hold_d, sh_d;
   logic [NB*LANES-1:0]  hold_be, sh_be;
   logic [1:0]           go;
   logic [LW-1:0]        left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_d      <= '0;
         hold_be     <= '0;
         sh_d        <= '0;
         sh_be       <= '0;
         go          <= '0;
         left        <= '0;
         mem_d       <= '0;
         mem_bmask_n <= '1;
      end else begin
         go <= {go[0], accept};
         if (accept) begin
            hold_d  <= wr_data;
            hold_be <= wr_be;
         end
         if (go[1]) begin
            mem_d       <= hold_d[DATA_W-1:0];
            mem_bmask_n <= ~hold_be[LANES-1:0];
            sh_d        <= hold_d >> DATA_W;
            sh_be       <= hold_be >> LANES;
            left        <= LW'(NB - 1);
         end else if (left != '0) begin
            mem_d       <= sh_d[DATA_W-1:0];
            mem_bmask_n <= ~sh_be[LANES-1:0];
            sh_d        <= sh_d >> DATA_W;
            sh_be       <= sh_be >> LANES;
            left        <= left - 1'b1;
         end else begin
            mem_d       <= '0;
            mem_bmask_n <= '1;
         end
      end
   end

   // R5: a new burst never cuts into a running one
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      go[1] |-> (left == '0));
endmodule

// File: rtl/qdr4_rd_capture.sv
`timescale 1ns/1ps
module qdr4_rd_capture #(
   parameter int DATA_W       = 36,
   parameter int RD_LAT_TICKS = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              accept,
   input  logic [DATA_W-1:0]                 mem_q,
   output logic                              rsp_valid,
   output logic [qdr4_pkg::BURST*DATA_W-1:0] rsp_data
);
   localparam int NB   = qdr4_pkg::BURST;
   localparam int PIPE = RD_LAT_TICKS + NB;

   if (RD_LAT_TICKS < 1) begin : g_bad_lat
      $error("RD_LAT_TICKS must be at least 1");
   end

   logic [PIPE-1:0] track;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         track     <= '0;
         rsp_valid <= 1'b0;
      end else begin
         track     <= {track[PIPE-2:0], accept};
         rsp_valid <= track[PIPE-1];
      end
   end

   for (genvar j = 0; j < NB; j++) begin : g_cap
      logic [DATA_W-1:0] beat_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       beat_r <= '0;
         else if (track[RD_LAT_TICKS + j]) beat_r <= mem_q;
      end
      assign rsp_data[j*DATA_W +: DATA_W] = beat_r;
   end

   // R8: response valid is a single-clock pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/qdr4_ctrl.sv
`timescale 1ns/1ps
module qdr4_ctrl #(
   parameter int ADDR_W       = 19,
   parameter int DATA_W       = 36,
   parameter int RD_LAT_TICKS = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   rd_req_valid,
   output logic                                   rd_req_ready,
   input  logic [ADDR_W-1:0]                      rd_req_addr,
   input  logic                                   wr_req_valid,
   output logic                                   wr_req_ready,
   input  logic [ADDR_W-1:0]                      wr_req_addr,
   input  logic [qdr4_pkg::BURST*DATA_W-1:0]      wr_req_data,
   input  logic [qdr4_pkg::BURST*(DATA_W/9)-1:0]  wr_req_be,
   output logic                                   rd_rsp_valid,
   output logic [qdr4_pkg::BURST*DATA_W-1:0]      rd_rsp_data,
   output logic                                   mem_kphase,
   output logic                                   mem_rsel_n,
   output logic [ADDR_W-1:0]                      mem_rd_addr,
   output logic                                   mem_wsel_n,
   output logic [ADDR_W-1:0]                      mem_wr_addr,
   output logic [DATA_W/9-1:0]                    mem_bmask_n,
   output logic [DATA_W-1:0]                      mem_d,
   input  logic [DATA_W-1:0]                      mem_q
);
   import qdr4_pkg::*;

   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of 9-bit lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   kphase_e ph;
   logic    launch, rd_accept, wr_accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_K_HIGH;
      else        ph <= (ph == PH_K_HIGH) ? PH_K_LOW : PH_K_HIGH;
   end

   assign launch     = (ph == PH_K_HIGH);
   assign mem_kphase = (ph == PH_K_HIGH);

   qdr4_port_issue #(.ADDR_W(ADDR_W)) u_rd_issue (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .req_valid(rd_req_valid), .req_addr(rd_req_addr),
      .req_ready(rd_req_ready), .accept(rd_accept),
      .sel_n(mem_rsel_n), .mem_addr(mem_rd_addr)
   );

   qdr4_port_issue #(.ADDR_W(ADDR_W)) u_wr_issue (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .req_valid(wr_req_valid), .req_addr(wr_req_addr),
      .req_ready(wr_req_ready), .accept(wr_accept),
      .sel_n(mem_wsel_n), .mem_addr(mem_wr_addr)
   );

   qdr4_wr_beats #(.DATA_W(DATA_W), .LANES(LANES)) u_wr_beats (
      .clk(clk), .rst_n(rst_n), .accept(wr_accept),
      .wr_data(wr_req_data), .wr_be(wr_req_be),
      .mem_d(mem_d), .mem_bmask_n(mem_bmask_n)
   );

   qdr4_rd_capture #(.DATA_W(DATA_W), .RD_LAT_TICKS(RD_LAT_TICKS)) u_rd_capture (
      .clk(clk), .rst_n(rst_n), .accept(rd_accept), .mem_q(mem_q),
      .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data)
   );

   // R7: masks stay high unless a write was selected within the last few ticks
   a_r7_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wsel_n && $past(mem_wsel_n) && $past(mem_wsel_n, 2) &&
       $past(mem_wsel_n, 3) && $past(mem_wsel_n, 4) && $past(mem_wsel_n, 5))
      |-> (&mem_bmask_n));

   // R2: a select only goes low right after the K-high half
   a_r2_sel_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rsel_n || !mem_wsel_n) |-> !mem_kphase);
endmodule

// File: tb/sim_qdr4_ctrl.sv
`timescale 1ns/1ps
module sim_qdr4_ctrl;
   localparam int AW = 19;
   localparam int DW = 36;
   localparam int NL = 4;
   localparam int WW = 4 * DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          rd_req_valid = 0, wr_req_valid = 0;
   logic          rd_req_ready, wr_req_ready;
   logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
   logic [WW-1:0] wr_req_data = '0;
   logic [4*NL-1:0] wr_req_be = '0;
   logic          rd_rsp_valid;
   logic [WW-1:0] rd_rsp_data;
   logic          mem_kphase, mem_rsel_n, mem_wsel_n;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic [NL-1:0] mem_bmask_n;
   logic [DW-1:0] mem_d;
   logic [DW-1:0] mem_q = '0;

   qdr4_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
      .wr_req_data(wr_req_data), .wr_req_be(wr_req_be),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .mem_kphase(mem_kphase), .mem_rsel_n(mem_rsel_n), .mem_rd_addr(mem_rd_addr),
      .mem_wsel_n(mem_wsel_n), .mem_wr_addr(mem_wr_addr),
      .mem_bmask_n(mem_bmask_n), .mem_d(mem_d), .mem_q(mem_q)
   );

   int checks = 0, errors = 0;
   longint tick = 0;
   always @(posedge clk) tick <= tick + 1;

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural memory responder ----------------
   logic [DW-1:0] array [longint];
   longint rd_at [longint];
   longint wr_at [longint];
   bit prev_r = 0, prev_w = 0;
   int ignored = 0;

   always @(posedge clk) begin
      longint now;
      now = tick;
      if (rst_n && !mem_kphase) begin
         if (!mem_rsel_n) begin
            if (prev_r) ignored++;
            else for (int j = 0; j < 4; j++) rd_at[now + 2 + j] = longint'({mem_rd_addr, 2'(j)});
         end
         if (!mem_wsel_n) begin
            if (prev_w) ignored++;
            else for (int j = 0; j < 4; j++) wr_at[now + 2 + j] = longint'({mem_wr_addr, 2'(j)});
         end
         prev_r = !mem_rsel_n;
         prev_w = !mem_wsel_n;
      end
      if (wr_at.exists(now)) begin
         logic [DW-1:0] w;
         w = array.exists(wr_at[now]) ? array[wr_at[now]] : '0;
         for (int i = 0; i < NL; i++)
            if (!mem_bmask_n[i]) w[i*9 +: 9] = mem_d[i*9 +: 9];
         array[wr_at[now]] = w;
         wr_at.delete(now);
      end
      if (rd_at.exists(now)) begin
         mem_q <= array.exists(rd_at[now]) ? array[rd_at[now]] : '0;
         rd_at.delete(now);
      end
   end

   // ---------------- scoreboard model ----------------
   logic [DW-1:0] model [longint];
   logic [WW-1:0] expq [$];
   longint        exp_t [$];
   longint last_rd_t = 0, last_wr_t = 0;

   function automatic logic [WW-1:0] pat(input int s);
      logic [WW-1:0] r;
      for (int j = 0; j < 4; j++)
         r[j*DW +: DW] = {4'(s + j), 32'(s * 32'h9E3779B1 + j * 32'h7F4A7C15)};
      return r;
   endfunction

   task automatic rd(input logic [AW-1:0] a);
      logic [WW-1:0] e;
      rd_req_valid = 1'b1;
      rd_req_addr  = a;
      while (!rd_req_ready) @(negedge clk);
      @(posedge clk);
      last_rd_t = tick + 1;
      for (int j = 0; j < 4; j++) begin
         longint k;
         k = longint'({a, 2'(j)});
         e[j*DW +: DW] = model.exists(k) ? model[k] : '0;
      end
      expq.push_back(e);
      exp_t.push_back(last_rd_t);
      @(negedge clk);
      rd_req_valid = 1'b0;
      chk(!mem_rsel_n && mem_rd_addr == a, "R2 read select/address", WW'({mem_rsel_n, mem_rd_addr}), WW'({1'b0, a}));
      chk(!rd_req_ready, "R3 read ready low after accept", WW'(rd_req_ready), 0);
      @(negedge clk);
      chk(mem_rsel_n, "R4 read select released", WW'(mem_rsel_n), 1);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d, input logic [4*NL-1:0] be);
      wr_req_valid = 1'b1;
      wr_req_addr  = a;
      wr_req_data  = d;
      wr_req_be    = be;
      while (!wr_req_ready) @(negedge clk);
      @(posedge clk);
      last_wr_t = tick + 1;
      for (int j = 0; j < 4; j++) begin
         longint k;
         logic [DW-1:0] w;
         k = longint'({a, 2'(j)});
         w = model.exists(k) ? model[k] : '0;
         for (int i = 0; i < NL; i++)
            if (be[j*NL + i]) w[i*9 +: 9] = d[j*DW + i*9 +: 9];
         model[k] = w;
      end
      @(negedge clk);
      wr_req_valid = 1'b0;
      chk(!mem_wsel_n && mem_wr_addr == a, "R2 write select/address", WW'({mem_wsel_n, mem_wr_addr}), WW'({1'b0, a}));
      chk(!wr_req_ready, "R3 write ready low after accept", WW'(wr_req_ready), 0);
      @(negedge clk);
      chk(mem_wsel_n, "R4 write select released", WW'(mem_wsel_n), 1);
   endtask

   // monitor: pops expected words as responses appear
   always @(negedge clk) begin
      if (rst_n && rd_rsp_valid) begin
         if (expq.size() == 0) begin
            chk(0, "R8 unexpected response", rd_rsp_data, 0);
         end else begin
            logic [WW-1:0] e;
            longint t;
            e = expq.pop_front();
            t = exp_t.pop_front();
            chk(rd_rsp_data == e, "R8 read data (R5/R6 write path)", rd_rsp_data, e);
            chk(tick == t + 7, "R8 response latency", WW'(tick - t), 7);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      longint t1, t2;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(mem_rsel_n && mem_wsel_n && &mem_bmask_n && !rd_rsp_valid,
          "R1 reset state", WW'({mem_rsel_n, mem_wsel_n, mem_bmask_n, rd_rsp_valid}), WW'(6'b111110));
      begin
         logic k0;
         k0 = mem_kphase;
         @(negedge clk);
         chk(mem_kphase != k0, "R1 kphase toggles", WW'(mem_kphase), WW'(~k0));
      end

      // R5: full write then read back
      wr(5, pat(1), '1);
      idle(8);
      rd(5);
      idle(10);

      // R6: sparse byte enables over existing data
      wr(5, pat(2), 16'hA5C3);
      idle(8);
      rd(5);
      idle(10);

      // R3: back-to-back reads and writes
      wr(9, pat(3), '1);
      idle(8);
      rd(5); t1 = last_rd_t;
      rd(9); t2 = last_rd_t;
      chk(t2 - t1 == 4, "R3 read spacing", WW'(t2 - t1), 4);
      idle(10);
      wr(20, pat(4), '1); t1 = last_wr_t;
      wr(21, pat(5), 16'h0FF0); t2 = last_wr_t;
      chk(t2 - t1 == 4, "R3 write spacing", WW'(t2 - t1), 4);
      idle(8);
      rd(20);
      rd(21);
      idle(10);

      // R9: read and write together
      fork
         rd(9);
         wr(30, pat(6), '1);
      join
      chk(last_rd_t == last_wr_t, "R9 same-edge accept", WW'(last_rd_t), WW'(last_wr_t));
      idle(10);
      rd(30);
      idle(12);

      // R7: idle bus
      chk(&mem_bmask_n && mem_d == '0, "R7 idle masks/data", WW'({mem_bmask_n, mem_d}), WW'({4'hF, 36'h0}));
      chk(ignored == 0, "R4 no request dropped by memory", WW'(ignored), 0);
      chk(expq.size() == 0, "R8 all responses returned", WW'(expq.size()), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule